// File: doc/BRIEF.md
# Synchronous Burst Memory with Dual Address Strobes

This block is a clocked on-chip memory of parameterised size. It is addressed the way a pipelined-bus burst memory is: at every rising clock edge it samples two address strobes, a burst-advance input, three chip selects and a set of write enables. From these it picks one of six actions: do nothing, deselect, load the address and read, load the address and write, step the burst, or hold the burst. A two-bit burst counter walks the low address bits inside an aligned four-word group. The upper bits keep the values they had when the address was loaded.

The processor strobe always opens a read. A write begins either when the controller strobe is sampled with write enables active, or on a later edge of a burst that is already open. Read data flows through from the registered address in the cycle after the loading edge. The bidirectional data bus is split at the pad boundary into write-data in, read-data out and a drive enable. The drive enable is gated without a clock by the output-enable pin. It is forced low during write cycles, when the burst is idle and while the sleep input is high.

While the sleep input is high, no sampled cycle takes effect and any open burst is dropped. After sleep is released, a fixed number of further edges are also ignored before normal operation resumes.

Top module: `burst_sram`

## Requirements
- R1: With any of the select inputs at its inactive level (ce1_ni high, ce2_i low or ce3_ni high), a strobe that would start a cycle instead closes the burst. The drive enable then stays low until a new address is loaded.
- R2: While ce1_ni is high, adsp_ni is ignored. adsc_ni low then deselects. With adsc_ni high, an open burst steps or holds exactly as it would with both strobes high.
- R3: adsp_ni low with the chip selected loads addr_i and starts a read, whatever the state of gw_ni, bwe_ni and bw_ni. The word at that address is on dq_o after that edge.
- R4: With both strobes inactive and a burst open, adv_ni low increments the low 2 address bits, wrapping from 3 to 0. The remaining address bits are unchanged.
- R5: With both strobes inactive and a burst open, adv_ni high keeps the current address.
- R6: With both strobes inactive, a burst open and write enables active, the edge writes dq_i to the next address (adv_ni low) or to the current address (adv_ni high). This also holds in a burst opened by adsp_ni.
- R7: adsc_ni low with adsp_ni inactive and the chip selected loads addr_i. It writes dq_i at that edge if any write enable is active, and starts a read otherwise.
- R8: Byte k is bits [8k+7:8k]. gw_ni low writes every byte. Otherwise, bwe_ni low writes each byte k whose bw_ni[k] is low. bwe_ni high with gw_ni high writes nothing.
- R9: dq_oe_o is high only when a read burst is open, oe_ni is low and sleep_i is low. oe_ni acts without waiting for a clock edge.
- R10: While sleep_i is high, dq_oe_o is low and no cycle takes effect, including writes. An open burst is closed.
- R11: The first 2 edges after sleep_i is sampled low are ignored. The third edge is the first one accepted.
- R12: After reset, no burst is open and dq_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, all sampling on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep request, active high |
| ce1_ni | input | 1 | Chip select, active low; also gates the processor strobe |
| ce2_i | input | 1 | Chip select, active high |
| ce3_ni | input | 1 | Chip select, active low |
| adsp_ni | input | 1 | Processor address strobe, active low |
| adsc_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| bw_ni | input | NB | Per-byte write selects, active low |
| oe_ni | input | 1 | Output enable, active low, unclocked |
| addr_i | input | AW | External address |
| dq_i | input | DW | Write data from the pad |
| dq_o | output | DW | Read data to the pad |
| dq_oe_o | output | 1 | Pad drive enable; low means high impedance |

## Verification
Every decode outcome is registered at a single rising edge, so its effect is visible from that edge until the next one. A read loaded or stepped at edge N shows its data and drive enable after edge N. A write at edge N only shows up when a later read reaches that address. The bench drives inputs at the falling edge and records the expected bus state just after the rising edge. It compares three time units later, while the inputs of that cycle, including the unclocked output enable, are still applied. Sleep and wake behaviour is checked by counting edges from the falling sleep input: reads and writes issued in the two blocked edges must leave no trace at the third.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [2:0] {
    CYC_NOP,
    CYC_DESEL,
    CYC_LOAD_RD,
    CYC_LOAD_WR,
    CYC_STEP,
    CYC_HOLD
  } cyc_e;
endpackage

// File: rtl/sram_decode.sv
module sram_decode
  import sram_pkg::*;
(
  input  logic accept_i,
  input  logic ce1_ni,
  input  logic ce2_i,
  input  logic ce3_ni,
  input  logic adsp_ni,
  input  logic adsc_ni,
  input  logic adv_ni,
  input  logic we_any_i,
  input  logic active_i,
  output cyc_e cyc_o
);
  logic sel;
  assign sel = !ce1_ni && ce2_i && !ce3_ni;

  always_comb begin
    cyc_o = CYC_NOP;
    if (!accept_i)
      cyc_o = CYC_DESEL;
    else if (!adsp_ni && !ce1_ni)          // processor strobe: read only
      cyc_o = sel ? CYC_LOAD_RD : CYC_DESEL;
    else if (!adsc_ni)
      cyc_o = !sel ? CYC_DESEL : (we_any_i ? CYC_LOAD_WR : CYC_LOAD_RD);
    else if (active_i)
      cyc_o = adv_ni ? CYC_HOLD : CYC_STEP;
  end
endmodule

// File: rtl/sram_byte_en.sv
module sram_byte_en #(
  parameter int NB = 2
) (
  input  logic          gw_ni,
  input  logic          bwe_ni,
  input  logic [NB-1:0] bw_ni,
  output logic [NB-1:0] be_o,
  output logic          we_any_o
);
  for (genvar g = 0; g < NB; g++) begin : g_be
    assign be_o[g] = !gw_ni || (!bwe_ni && !bw_ni[g]);
  end
  assign we_any_o = |be_o;
endmodule

// File: rtl/sram_burst.sv
module sram_burst
  import sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int BB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cyc_e          cyc_i,
  input  logic          we_any_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_q_o,
  output logic [AW-1:0] tgt_addr_o,
  output logic          active_o,
  output logic          wr_mode_o,
  output logic          wr_en_o
);
  logic [AW-1:0] addr_q, step_addr;
  logic          active_q, wr_q;

  // wrap inside the aligned group; upper bits frozen
  assign step_addr = {addr_q[AW-1:BB], addr_q[BB-1:0] + BB'(1)};

  always_comb begin
    case (cyc_i)
      CYC_LOAD_RD, CYC_LOAD_WR: tgt_addr_o = addr_i;
      CYC_STEP:                 tgt_addr_o = step_addr;
      default:                  tgt_addr_o = addr_q;
    endcase
  end

  assign wr_en_o = (cyc_i == CYC_LOAD_WR) ||
                   (((cyc_i == CYC_STEP) || (cyc_i == CYC_HOLD)) && we_any_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      active_q <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      case (cyc_i)
        CYC_DESEL: begin
          active_q <= 1'b0;
          wr_q     <= 1'b0;
        end
        CYC_LOAD_RD: begin
          active_q <= 1'b1;
          wr_q     <= 1'b0;
          addr_q   <= addr_i;
        end
        CYC_LOAD_WR: begin
          active_q <= 1'b1;
          wr_q     <= 1'b1;
          addr_q   <= addr_i;
        end
        CYC_STEP, CYC_HOLD: begin
          addr_q <= tgt_addr_o;
          wr_q   <= we_any_i;
        end
        default: ;
      endcase
    end
  end

  assign addr_q_o  = addr_q;
  assign active_o  = active_q;
  assign wr_mode_o = wr_q;
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int NB = 2
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [NB-1:0] be_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int BW    = DW / NB;
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BW-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[g]) mem[waddr_i] <= wdata_i[g*BW +: BW];
    end
    assign rdata_o[g*BW +: BW] = mem[raddr_i];
  end
endmodule

// File: rtl/sram_sleep.sv
module sram_sleep #(
  parameter int WAKE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  output logic accept_o
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (sleep_i)      cnt_q <= CW'(WAKE_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign accept_o = !sleep_i && (cnt_q == '0);
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sram_pkg::*;
#(
  parameter int AW       = 6,
  parameter int DW       = 16,
  parameter int NB       = 2,
  parameter int BB       = 2,
  parameter int WAKE_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sleep_i,
  input  logic          ce1_ni,
  input  logic          ce2_i,
  input  logic          ce3_ni,
  input  logic          adsp_ni,
  input  logic          adsc_ni,
  input  logic          adv_ni,
  input  logic          gw_ni,
  input  logic          bwe_ni,
  input  logic [NB-1:0] bw_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  cyc_e          cyc;
  logic          accept, we_any, active_q, wr_q, wr_en;
  logic [NB-1:0] be;
  logic [AW-1:0] addr_q, tgt_addr;

  sram_sleep #(.WAKE_CYC(WAKE_CYC)) u_sleep (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .accept_o(accept)
  );

  sram_byte_en #(.NB(NB)) u_be (
    .gw_ni(gw_ni), .bwe_ni(bwe_ni), .bw_ni(bw_ni), .be_o(be), .we_any_o(we_any)
  );

  sram_decode u_dec (
    .accept_i(accept), .ce1_ni(ce1_ni), .ce2_i(ce2_i), .ce3_ni(ce3_ni),
    .adsp_ni(adsp_ni), .adsc_ni(adsc_ni), .adv_ni(adv_ni),
    .we_any_i(we_any), .active_i(active_q), .cyc_o(cyc)
  );

  sram_burst #(.AW(AW), .BB(BB)) u_burst (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_i(cyc), .we_any_i(we_any),
    .addr_i(addr_i), .addr_q_o(addr_q), .tgt_addr_o(tgt_addr),
    .active_o(active_q), .wr_mode_o(wr_q), .wr_en_o(wr_en)
  );

  sram_array #(.AW(AW), .DW(DW), .NB(NB)) u_mem (
    .clk_i(clk_i), .we_i(wr_en), .be_i(be), .waddr_i(tgt_addr),
    .wdata_i(dq_i), .raddr_i(addr_q), .rdata_o(dq_o)
  );

  // oe and sleep act without a clock; writes mask the driver
  assign dq_oe_o = active_q && !wr_q && !oe_ni && !sleep_i;
endmodule

// File: rtl/sram_chk.sv
module sram_chk #(
  parameter int AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sleep_i,
  input logic          ce1_ni,
  input logic          ce2_i,
  input logic          ce3_ni,
  input logic          adsp_ni,
  input logic          adsc_ni,
  input logic          adv_ni,
  input logic [AW-1:0] addr_i,
  input logic          accept,
  input logic          active_q,
  input logic          wr_q,
  input logic [AW-1:0] addr_q
);
  p_desel_sel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (!ce2_i || ce3_ni) && (!adsc_ni || (!adsp_ni && !ce1_ni))) |=> !active_q);

  p_ce1_desel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsc_ni && ce1_ni) |=> !active_q);

  p_adsp_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !adsp_ni && !ce1_ni && ce2_i && !ce3_ni)
      |=> (active_q && !wr_q && addr_q == $past(addr_i)));

  p_adv_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && active_q && adsc_ni && (adsp_ni || ce1_ni) && !adv_ni)
      |=> (addr_q[1:0] == $past(addr_q[1:0]) + 2'd1 &&
           addr_q[AW-1:2] == $past(addr_q[AW-1:2])));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && active_q && adsc_ni && (adsp_ni || ce1_ni) && adv_ni)
      |=> (active_q && $stable(addr_q)));

  p_sleep_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !active_q);

  p_wake_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !active_q);
endmodule

bind burst_sram sram_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .ce1_ni(ce1_ni),
  .ce2_i(ce2_i), .ce3_ni(ce3_ni), .adsp_ni(adsp_ni), .adsc_ni(adsc_ni),
  .adv_ni(adv_ni), .addr_i(addr_i), .accept(accept), .active_q(active_q),
  .wr_q(wr_q), .addr_q(addr_q)
);

// File: tb/sim_burst_sram.sv
module sim_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] SEL = 3'b010; // {ce1_n, ce2, ce3_n}

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sleep = 1'b0, ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic        adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic        gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b1;
  logic [1:0]  bw_n = 2'b11;
  logic [5:0]  addr = '0;
  logic [15:0] din = '0, dout;
  logic        doe;

  int errs = 0, checks = 0;
  bit done = 1'b0;

  logic        q_oe[$];
  logic [15:0] q_dat[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram u0 (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .ce1_ni(ce1_n), .ce2_i(ce2),
    .ce3_ni(ce3_n), .adsp_ni(adsp_n), .adsc_ni(adsc_n), .adv_ni(adv_n),
    .gw_ni(gw_n), .bwe_ni(bwe_n), .bw_ni(bw_n), .oe_ni(oe_n), .addr_i(addr),
    .dq_i(din), .dq_o(dout), .dq_oe_o(doe)
  );

  task automatic step(input logic [2:0] c, input logic s, input logic [5:0] a,
                      input logic sp, input logic sc, input logic av,
                      input logic g, input logic be, input logic [1:0] b,
                      input logic o, input logic [15:0] d,
                      input logic eoe, input logic [15:0] edat, input string tag);
    @(negedge clk);
    {ce1_n, ce2, ce3_n} = c;
    sleep = s; addr = a; adsp_n = sp; adsc_n = sc; adv_n = av;
    gw_n = g; bwe_n = be; bw_n = b; oe_n = o; din = d;
    @(posedge clk);
    #1;
    q_oe.push_back(eoe); q_dat.push_back(edat); q_tag.push_back(tag);
  endtask

  // monitor: result of each edge, sampled while that cycle's inputs hold
  always @(posedge clk) begin
    #3;
    if (q_oe.size() > 0) begin
      logic        eoe;
      logic [15:0] edat;
      string       tag;
      eoe = q_oe.pop_front(); edat = q_dat.pop_front(); tag = q_tag.pop_front();
      checks++;
      if (doe !== eoe || (eoe && dout !== edat)) begin
        errs++;
        $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h",
                 tag, doe, dout, eoe, edat);
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: oe=%b data=%h expected oe=0 data=0", doe, dout);
      finish_run();
    end
  end

  initial begin
    #(CLK_PERIOD*2 + 2);
    rst_n = 1'b1;
    checks++;
    if (doe !== 1'b0) begin
      errs++;
      $display("FAIL R12 reset: oe=%b expected oe=0", doe);
    end
    // R7/R6/R4/R5 write burst
    step(SEL,0,6'd4, 1,0,1, 0,1,2'b11, 1,16'h1111, 0,16'h0, "R7 adsc write masks bus");
    step(SEL,0,6'd0, 1,1,0, 0,1,2'b11, 1,16'h2222, 0,16'h0, "R6 step write");
    step(SEL,0,6'd0, 1,1,0, 0,1,2'b11, 1,16'h3333, 0,16'h0, "R6 step write");
    step(SEL,0,6'd0, 1,1,0, 0,1,2'b11, 1,16'h4444, 0,16'h0, "R6 step write");
    step(SEL,0,6'd0, 1,1,0, 0,1,2'b11, 1,16'h5555, 0,16'h0, "R4 write wrap");
    step(SEL,0,6'd0, 1,1,1, 0,1,2'b11, 1,16'h6666, 0,16'h0, "R5 write hold");
    // R3 read burst, write enables active on the loading edge
    step(SEL,0,6'd4, 0,1,1, 0,0,2'b00, 0,16'hFFFF, 1,16'h6666, "R3 adsp read");
    step(SEL,0,6'd0, 1,1,0, 1,1,2'b11, 0,16'h0, 1,16'h2222, "R4 read step");
    step(SEL,0,6'd0, 1,1,0, 1,1,2'b11, 0,16'h0, 1,16'h3333, "R4 read step");
    step(SEL,0,6'd0, 1,1,0, 1,1,2'b11, 0,16'h0, 1,16'h4444, "R4 read step");
    step(SEL,0,6'd0, 1,1,0, 1,1,2'b11, 0,16'h0, 1,16'h6666, "R4 read wrap");
    step(SEL,0,6'd0, 1,1,1, 1,1,2'b11, 0,16'h0, 1,16'h6666, "R5 read hold");
    step(SEL,0,6'd0, 1,1,1, 1,1,2'b11, 1,16'h0, 0,16'h0, "R9 oe high floats");
    // R8 byte writes
    step(SEL,0,6'd10, 1,0,1, 0,1,2'b11, 1,16'h1234, 0,16'h0, "R8 full write");
    step(SEL,0,6'd10, 1,0,1, 1,0,2'b10, 1,16'hABCD, 0,16'h0, "R8 byte0 write");
    step(SEL,0,6'd10, 1,0,1, 1,0,2'b01, 1,16'h5678, 0,16'h0, "R8 byte1 write");
    step(SEL,0,6'd10, 1,0,1, 1,1,2'b00, 0,16'hFFFF, 1,16'h56CD, "R7 R8 adsc read, bwe off");
    // R6 write following an adsp read
    step(SEL,0,6'd20, 1,0,1, 0,1,2'b11, 1,16'hAAAA, 0,16'h0, "R7 adsc write");
    step(SEL,0,6'd0,  1,1,0, 0,1,2'b11, 1,16'hBBBB, 0,16'h0, "R6 step write");
    step(SEL,0,6'd20, 0,1,1, 1,1,2'b11, 0,16'h0, 1,16'hAAAA, "R3 adsp read");
    step(SEL,0,6'd0,  1,1,1, 0,1,2'b11, 1,16'hCCCC, 0,16'h0, "R6 write current");
    step(SEL,0,6'd0,  1,1,0, 0,1,2'b11, 1,16'hDDDD, 0,16'h0, "R6 write next");
    step(SEL,0,6'd20, 0,1,1, 1,1,2'b11, 0,16'h0, 1,16'hCCCC, "R6 current written");
    step(SEL,0,6'd0,  1,1,0, 1,1,2'b11, 0,16'h0, 1,16'hDDDD, "R6 next written");
    // R1/R2 selects
    step(3'b000,0,6'd4, 0,1,1, 1,1,2'b11, 0,16'h0, 0,16'h0, "R1 ce2 low deselects");
    step(SEL,0,6'd0,    1,1,0, 1,1,2'b11, 0,16'h0, 0,16'h0, "R1 stays idle");
    step(3'b011,0,6'd4, 1,0,1, 1,1,2'b11, 0,16'h0, 0,16'h0, "R1 ce3 high deselects");
    step(SEL,0,6'd4,    0,1,1, 1,1,2'b11, 0,16'h0, 1,16'h6666, "R3 adsp read");
    step(3'b110,0,6'd9, 0,1,0, 1,1,2'b11, 0,16'h0, 1,16'h2222, "R2 adsp ignored, burst steps");
    step(3'b110,0,6'd9, 1,0,1, 1,1,2'b11, 0,16'h0, 0,16'h0, "R2 adsc deselects");
    step(SEL,0,6'd0,    1,1,0, 1,1,2'b11, 0,16'h0, 0,16'h0, "R2 stays idle");
    // R10/R11 sleep and wake
    step(SEL,0,6'd4, 0,1,1, 1,1,2'b11, 0,16'h0, 1,16'h6666, "R3 adsp read");
    step(SEL,1,6'd0, 1,1,1, 1,1,2'b11, 0,16'h0, 0,16'h0, "R10 sleep floats");
    step(SEL,1,6'd4, 1,0,1, 0,1,2'b11, 1,16'h9999, 0,16'h0, "R10 write in sleep");
    step(SEL,0,6'd5, 1,0,1, 0,1,2'b11, 1,16'h7777, 0,16'h0, "R11 wake edge 1");
    step(SEL,0,6'd4, 0,1,1, 1,1,2'b11, 0,16'h0, 0,16'h0, "R11 wake edge 2");
    step(SEL,0,6'd4, 0,1,1, 1,1,2'b11, 0,16'h0, 1,16'h6666, "R10 sleep write dropped");
    step(SEL,0,6'd0, 1,1,0, 1,1,2'b11, 0,16'h0, 1,16'h2222, "R11 wake write dropped");
    @(negedge clk);
    adsp_n = 1'b1; adsc_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(posedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule